// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block keeps a word of `WIDTH` bits (eight by default) and exchanges it with a shared parallel data bus. The bus is split into three vectors: `bus_out` carries the stored word, `bus_oe` says when the word may be driven onto the lines, and `bus_in` returns the level seen on the lines. A two-bit select picks one of four operations, applied at each rising clock edge:

- hold the word;
- shift it toward the high end;
- shift it toward the low end;
- capture the bus.

Two active-low enables gate the bus drivers. Selecting capture always releases the bus, so that another agent can place a word on it.

Two serial inputs supply the bit that enters at either end during a shift. The two end bits are brought out on outputs that are never gated. Several instances can therefore be chained into a longer word in either direction.

An active-low clear empties the register at once, with no clock needed. Its release is taken up through a short synchronizer. A synchronous active-high reset also zeroes the word.

Top module: `ushift_reg`

## Requirements
- R1: With `sel` = 2'b00 (hold), a rising edge leaves the stored word unchanged.
- R2: With `sel` = 2'b01 (shift up), a rising edge moves bit i into bit i+1, and `ser_r` enters bit 0.
- R3: With `sel` = 2'b10 (shift down), a rising edge moves bit i+1 into bit i, and `ser_l` enters bit WIDTH-1.
- R4: With `sel` = 2'b11 (capture), a rising edge stores `bus_in`.
- R5: `bus_oe` is 1 only when `oe1_n` and `oe2_n` are both 0 and `sel` is not 2'b11. It is 0 in every other case, including capture with both enables low.
- R6: Driving `clr_n` low zeroes the word at once, with no clock edge. This happens whatever the state of the bus enables.
- R7: After `clr_n` returns high, the word stays zero through the next two rising edges. The selected operation takes effect from the third edge.
- R8: Hold, shift and capture behave the same whether the bus drivers are enabled or disabled.
- R9: `first_q` always equals bit 0 of the word and `last_q` always equals bit WIDTH-1, whether `bus_oe` is 0 or 1.
- R10: `rst` high at a rising edge zeroes the word, whatever `sel` is.
- R11: Two instances, with `last_q` of the low one feeding `ser_r` of the high one and `first_q` of the high one feeding `ser_l` of the low one, shift a 2*WIDTH-bit word correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Asynchronous clear, active low, release synchronized |
| sel | input | 2 | Operation select: 00 hold, 01 shift up, 10 shift down, 11 capture |
| oe1_n | input | 1 | Bus drive enable, active low |
| oe2_n | input | 1 | Bus drive enable, active low |
| ser_r | input | 1 | Serial bit entering bit 0 on shift up |
| ser_l | input | 1 | Serial bit entering bit WIDTH-1 on shift down |
| bus_in | input | WIDTH | Level sampled from the shared data lines |
| bus_out | output | WIDTH | Stored word presented to the line drivers |
| bus_oe | output | 1 | Line driver enable |
| first_q | output | 1 | Bit 0 of the word, never gated |
| last_q | output | 1 | Bit WIDTH-1 of the word, never gated |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is capture and bus output. A capture is requested while both drive enables are held low. The bench checks before the edge that `bus_oe` has already dropped, and checks after the edge that the word on `bus_in` was stored.

The second pair is the clear and the synchronous datapath. `clr_n` is lowered half a cycle before an edge, with a capture and disabled drivers selected. The word must read zero without any edge. After release, a pending capture must stay blocked for exactly two edges.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_CAPT = 2'b11
  } mode_e;
endpackage

// File: rtl/ushift_clr_sync.sv
module ushift_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic clr_ok
);
  logic [STAGES-1:0] stg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], 1'b1};
  end

  assign clr_ok = stg[STAGES-1];
endmodule

// File: rtl/ushift_next.sv
module ushift_next
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e            mode,
  input  logic [WIDTH-1:0] q,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] nxt
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_lo;
    logic from_hi;
    if (i == 0) begin : g_lo_edge
      assign from_lo = ser_r;
    end else begin : g_lo_mid
      assign from_lo = q[i-1];
    end
    if (i == WIDTH-1) begin : g_hi_edge
      assign from_hi = ser_l;
    end else begin : g_hi_mid
      assign from_hi = q[i+1];
    end
    always_comb begin
      case (mode)
        MODE_UP:   nxt[i] = from_lo;
        MODE_DOWN: nxt[i] = from_hi;
        MODE_CAPT: nxt[i] = bus_in[i];
        default:   nxt[i] = q[i];
      endcase
    end
  end
endmodule

// File: rtl/ushift_bus_ctl.sv
module ushift_bus_ctl
  import ushift_pkg::*;
(
  input  mode_e mode,
  input  logic  oe1_n,
  input  logic  oe2_n,
  output logic  bus_oe
);
  // capture releases the lines no matter what the enables ask for
  assign bus_oe = !oe1_n && !oe2_n && (mode != MODE_CAPT);
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic [1:0]       sel,
  input  logic             oe1_n,
  input  logic             oe2_n,
  input  logic             ser_r,
  input  logic             ser_l,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             first_q,
  output logic             last_q
);
  mode_e            mode;
  logic             clr_ok;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] nxt;

  assign mode = mode_e'(sel);

  ushift_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .clr_n  (clr_n),
    .clr_ok (clr_ok)
  );

  ushift_next #(.WIDTH(WIDTH)) u_next (
    .mode   (mode),
    .q      (q),
    .ser_r  (ser_r),
    .ser_l  (ser_l),
    .bus_in (bus_in),
    .nxt    (nxt)
  );

  ushift_bus_ctl u_bus (
    .mode   (mode),
    .oe1_n  (oe1_n),
    .oe2_n  (oe2_n),
    .bus_oe (bus_oe)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)              q <= '0;
    else if (rst || !clr_ok) q <= '0;
    else                     q <= nxt;
  end

  assign bus_out = q;
  assign first_q = q[0];
  assign last_q  = q[WIDTH-1];
endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_n,
  input logic             clr_ok,
  input logic [1:0]       sel,
  input logic             oe1_n,
  input logic             oe2_n,
  input logic             ser_r,
  input logic             ser_l,
  input logic [WIDTH-1:0] bus_in,
  input logic [WIDTH-1:0] bus_out,
  input logic             bus_oe
);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (sel == 2'b00 && clr_ok) |=> $stable(bus_out));

  p_up_r2: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (sel == 2'b01 && clr_ok) |=> bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_r)});

  p_down_r3: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (sel == 2'b10 && clr_ok) |=> bus_out == {$past(ser_l), $past(bus_out[WIDTH-1:1])});

  p_capt_r4: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (sel == 2'b11 && clr_ok) |=> bus_out == $past(bus_in));

  p_capt_float_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b11) |-> !bus_oe);

  p_off_float_r5: assert property (@(posedge clk) disable iff (rst)
    (oe1_n || oe2_n) |-> !bus_oe);

  p_rst_r10: assert property (@(posedge clk) disable iff (!clr_n)
    rst |=> bus_out == '0);

  p_release_r7: assert property (@(posedge clk) disable iff (rst || !clr_n)
    !clr_ok |=> bus_out == '0);
endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .clr_n   (clr_n),
  .clr_ok  (clr_ok),
  .sel     (sel),
  .oe1_n   (oe1_n),
  .oe2_n   (oe2_n),
  .ser_r   (ser_r),
  .ser_l   (ser_l),
  .bus_in  (bus_in),
  .bus_out (bus_out),
  .bus_oe  (bus_oe)
);

// File: tb/sim_ushift_reg.sv
module sim_ushift_reg;
  localparam int W  = 8;
  localparam int NV = 8;
  // row: {sel, oe1_n, oe2_n, ser_r, ser_l, bus_in, expected word, expected bus_oe}
  localparam logic [22:0] VEC [NV] = '{
    {2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5, 1'b0},
    {2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'hA5, 1'b1},
    {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h4B, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 8'h96, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'hCB, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h65, 1'b1},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h3C, 1'b0}
  };

  logic clk = 1'b0;
  logic rst, clr_n, oe1_n, oe2_n, ser_r, tb_sl, ser_l_hi, casc;
  logic [1:0] sel;
  logic [W-1:0] din0, din1;
  logic [W-1:0] q0, q1;
  logic oe0, oe1, f0, l0, f1, l1, sl0;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign sl0 = casc ? f1 : tb_sl;

  ushift_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sel(sel), .oe1_n(oe1_n), .oe2_n(oe2_n),
    .ser_r(ser_r), .ser_l(sl0), .bus_in(din0), .bus_out(q0), .bus_oe(oe0),
    .first_q(f0), .last_q(l0));

  ushift_reg #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .clr_n(clr_n), .sel(sel), .oe1_n(oe1_n), .oe2_n(oe2_n),
    .ser_r(l0), .ser_l(ser_l_hi), .bus_in(din1), .bus_out(q1), .bus_oe(oe1),
    .first_q(f1), .last_q(l1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2*W-1:0] w;
    rst = 1'b1; clr_n = 1'b0; sel = 2'b00; oe1_n = 1'b0; oe2_n = 1'b0;
    ser_r = 1'b0; tb_sl = 1'b0; ser_l_hi = 1'b0; casc = 1'b0;
    din0 = '0; din1 = '0;
    @(negedge clk); clr_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset state", q0, 0);
    rst = 1'b0;

    // table walk: R1..R5, R8 (rows 4,5,7,8 run with drivers off), R9
    for (int k = 0; k < NV; k++) begin
      {sel, oe1_n, oe2_n, ser_r, tb_sl, din0} = VEC[k][22:9];
      #1;
      chk($sformatf("R5 bus_oe row %0d", k), oe0, VEC[k][0]);
      @(negedge clk);
      chk($sformatf("R1-4/R8 word row %0d", k), q0, VEC[k][8:1]);
      chk($sformatf("R9 first_q row %0d", k), f0, VEC[k][1]);
      chk($sformatf("R9 last_q row %0d", k), l0, VEC[k][8]);
    end

    // R10: reset beats a capture
    sel = 2'b11; din0 = 8'hFF; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 rst over capture", q0, 0);
    @(negedge clk);
    chk("R4 capture FF", q0, 8'hFF);

    // R6: clear with drivers off, no clock edge in between
    oe1_n = 1'b1; clr_n = 1'b0; #1;
    chk("R6 async clear", q0, 0);
    chk("R9 last_q with bus off", l0, 0);
    @(negedge clk);
    // R7: release with capture pending; two edges blocked
    clr_n = 1'b1; din0 = 8'h5A;
    @(negedge clk); chk("R7 release edge 1", q0, 0);
    @(negedge clk); chk("R7 release edge 2", q0, 0);
    @(negedge clk); chk("R7 release edge 3", q0, 8'h5A);

    // R11: cascade of two, 16-bit word {u1,u0}
    oe1_n = 1'b0; casc = 1'b1; w = 16'hC3A1;
    din0 = w[7:0]; din1 = w[15:8]; sel = 2'b11;
    @(negedge clk);
    chk("R11 cascade capture", {q1, q0}, w);
    sel = 2'b01;
    for (int k = 0; k < 3; k++) begin
      ser_r = k[0];
      w = {w[14:0], ser_r};
      @(negedge clk);
      chk($sformatf("R11 cascade up %0d", k), {q1, q0}, w);
    end
    sel = 2'b10;
    for (int k = 0; k < 3; k++) begin
      ser_l_hi = ~k[0];
      w = {ser_l_hi, w[15:1]};
      @(negedge clk);
      chk($sformatf("R11 cascade down %0d", k), {q1, q0}, w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule